// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block keeps the write-protect flag of a word-wide flash store. The flag can only be moved by software through seven back-to-back read accesses whose addresses form a fixed pattern. Two patterns exist. They share their first six addresses and differ only in the seventh. One pattern clears the flag and the other sets it. The data bus plays no part and is not an input of the block.

The block watches the store's three active-low bus strobes and its address, sampled on a system clock. A read access is decoded from the strobes. The address that counts for a read is the one present during the access, just before the first of chip-enable or output-enable goes high. The start of any write access abandons a pattern in progress, and no write ever alters the flag.

Program and erase requests from the command decoder are granted only while the flag is clear. A one-cycle pulse marks every change of the flag.

Top module: `swp_guard`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, protect_o is 1 and prot_chg_o is 0.
- R2: A read is active in a clock sample when ce_n_i=0, oe_n_i=0 and we_n_i=1. The read ends at the first sample that is no longer active, whether oe_n_i or ce_n_i rose. Its address is the addr_i seen in the read's last active sample, and addr_i at the ending sample is ignored. A read held active for many samples counts once.
- R3: Seven consecutive read ends at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h and 041Ah clear protect_o. The change is visible in the cycle after the clock that samples the seventh read end.
- R4: Seven consecutive read ends at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h and 040Ah set protect_o, with the same timing as R3.
- R5: A read end whose address is not the next one expected restarts matching. If that address is 1823h, it counts as the first step of a new attempt.
- R6: A write starts at a sample with ce_n_i=0 and we_n_i=0 that follows a sample without that condition. A write start cancels any pattern in progress, and it wins over a read end in the same sample. A write never changes protect_o, whatever command it carries (for example FFFFh).
- R7: pgm_grant_o equals pgm_req_i and ers_grant_o equals ers_req_i while protect_o is 0. Both grants are 0 while protect_o is 1. The grants are combinational.
- R8: prot_chg_o is high for exactly one cycle, in the same cycle that protect_o first shows a new value. A completed pattern that leaves the flag unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable strobe, active low, synchronous to clk_i |
| oe_n_i | input | 1 | Output enable strobe, active low, synchronous to clk_i |
| we_n_i | input | 1 | Write enable strobe, active low, synchronous to clk_i |
| addr_i | input | 16 | Word address of the current access |
| pgm_req_i | input | 1 | Program request from the command decoder |
| ers_req_i | input | 1 | Erase request from the command decoder |
| protect_o | output | 1 | Write-protect flag, 1 = protected |
| prot_chg_o | output | 1 | One-cycle pulse on any change of protect_o |
| pgm_grant_o | output | 1 | Program request allowed |
| ers_grant_o | output | 1 | Erase request allowed |

## Verification
A read end is seen at the clock that first samples the strobes released. The flag and the change pulse move one cycle after that clock, and the pulse drops again one cycle later. The grants follow the requests within the same cycle. The bench changes inputs only on the falling clock edge and advances its behavioural model on the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned SEQ_LEN = 7;
  localparam logic [ADDR_W-1:0] LAST_CLR = 16'h041A;
  localparam logic [ADDR_W-1:0] LAST_SET = 16'h040A;

  // shared prefix of both patterns; index SEQ_LEN-1 is decided separately
  function automatic logic [ADDR_W-1:0] seq_addr(input int unsigned k);
    case (k)
      0:       seq_addr = 16'h1823;
      1:       seq_addr = 16'h1820;
      2:       seq_addr = 16'h1822;
      3:       seq_addr = 16'h0418;
      4:       seq_addr = 16'h041B;
      5:       seq_addr = 16'h0419;
      default: seq_addr = '1;
    endcase
  endfunction
endpackage

// File: rtl/swp_bus_event.sv
module swp_bus_event #(
  parameter int unsigned AW = swp_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_end_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_start_o
);
  logic          rd_act, wr_act;
  logic          rd_act_q, wr_act_q;
  logic [AW-1:0] addr_q;

  assign rd_act = ~ce_n_i & ~oe_n_i & we_n_i;
  assign wr_act = ~ce_n_i & ~we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      if (rd_act) addr_q <= addr_i;
    end
  end

  assign rd_end_o   = rd_act_q & ~rd_act;
  assign rd_addr_o  = addr_q;
  assign wr_start_o = wr_act & ~wr_act_q;
endmodule

// File: rtl/swp_seq_match.sv
module swp_seq_match #(
  parameter int unsigned AW      = swp_pkg::ADDR_W,
  parameter int unsigned SEQ_LEN = swp_pkg::SEQ_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_end_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_start_i,
  output logic          hit_clr_o,
  output logic          hit_set_o
);
  localparam int unsigned STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0]  step_q, step_d;
  logic [SEQ_LEN-1:0] step_eq;

  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_cmp
    if (k == SEQ_LEN - 1) begin : g_last
      assign step_eq[k] = 1'b0;
    end else begin : g_pre
      assign step_eq[k] = (rd_addr_i == swp_pkg::seq_addr(k));
    end
  end

  always_comb begin
    step_d    = step_q;
    hit_clr_o = 1'b0;
    hit_set_o = 1'b0;
    if (wr_start_i) begin
      step_d = '0;
    end else if (rd_end_i) begin
      if (step_q == LAST) begin
        hit_clr_o = (rd_addr_i == swp_pkg::LAST_CLR);
        hit_set_o = (rd_addr_i == swp_pkg::LAST_SET);
      end
      if (step_q != LAST && step_eq[step_q]) step_d = step_q + STEP_W'(1);
      else if (step_eq[0])                   step_d = STEP_W'(1);
      else                                   step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/swp_flag.sv
module swp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_clr_i,
  input  logic hit_set_i,
  output logic protect_o,
  output logic chg_o
);
  logic prot_q, chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= (hit_clr_i & prot_q) | (hit_set_i & ~prot_q);
      if (hit_clr_i)      prot_q <= 1'b0;
      else if (hit_set_i) prot_q <= 1'b1;
    end
  end

  assign protect_o = prot_q;
  assign chg_o     = chg_q;
endmodule

// File: rtl/swp_guard.sv
module swp_guard #(
  parameter int unsigned AW      = swp_pkg::ADDR_W,
  parameter int unsigned SEQ_LEN = swp_pkg::SEQ_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          pgm_req_i,
  input  logic          ers_req_i,
  output logic          protect_o,
  output logic          prot_chg_o,
  output logic          pgm_grant_o,
  output logic          ers_grant_o
);
  logic          rd_end, wr_start, hit_clr, hit_set;
  logic [AW-1:0] rd_addr;

  swp_bus_event #(.AW(AW)) u_event (
    .clk_i, .rst_ni, .ce_n_i, .oe_n_i, .we_n_i, .addr_i,
    .rd_end_o(rd_end), .rd_addr_o(rd_addr), .wr_start_o(wr_start)
  );

  swp_seq_match #(.AW(AW), .SEQ_LEN(SEQ_LEN)) u_match (
    .clk_i, .rst_ni,
    .rd_end_i(rd_end), .rd_addr_i(rd_addr), .wr_start_i(wr_start),
    .hit_clr_o(hit_clr), .hit_set_o(hit_set)
  );

  swp_flag u_flag (
    .clk_i, .rst_ni,
    .hit_clr_i(hit_clr), .hit_set_i(hit_set),
    .protect_o(protect_o), .chg_o(prot_chg_o)
  );

  assign pgm_grant_o = pgm_req_i & ~protect_o;
  assign ers_grant_o = ers_req_i & ~protect_o;
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic protect_o,
  input logic prot_chg_o,
  input logic pgm_req_i,
  input logic ers_req_i,
  input logic pgm_grant_o,
  input logic ers_grant_o,
  input logic wr_start
);
  a_r7_locked_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_o |-> (!pgm_grant_o && !ers_grant_o));

  a_r7_open_passes_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !protect_o |-> (pgm_grant_o == pgm_req_i && ers_grant_o == ers_req_i));

  a_r8_change_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o != $past(protect_o)) |-> prot_chg_o);

  a_r8_pulse_means_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_chg_o |-> (protect_o != $past(protect_o)));

  a_r8_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_chg_o |=> !prot_chg_o);

  a_r6_write_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> $stable(protect_o));
endmodule

bind swp_guard swp_guard_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .protect_o(protect_o), .prot_chg_o(prot_chg_o),
  .pgm_req_i(pgm_req_i), .ers_req_i(ers_req_i),
  .pgm_grant_o(pgm_grant_o), .ers_grant_o(ers_grant_o), .wr_start(wr_start)
);

// File: tb/swp_guard_tb.sv
module swp_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic pgm_req = 1'b0, ers_req = 1'b0;
  logic protect, prot_chg, pgm_grant, ers_grant;

  int vecs = 0, errs = 0;
  string cur = "R1";

  // model state
  int  m_step = 0;
  bit  m_flag = 1, m_chg = 0, m_prev_rd = 0, m_prev_wr = 0;
  logic [15:0] m_addr = '0;
  int  pre_seq[6] = '{'h1823, 'h1820, 'h1822, 'h0418, 'h041B, 'h0419};

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .pgm_req_i(pgm_req), .ers_req_i(ers_req),
    .protect_o(protect), .prot_chg_o(prot_chg),
    .pgm_grant_o(pgm_grant), .ers_grant_o(ers_grant)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rd_act, wr_act, rd_end, wr_start, nf;
    rd_act = !ce_n && !oe_n && we_n;
    wr_act = !ce_n && !we_n;
    rd_end = m_prev_rd && !rd_act;
    wr_start = wr_act && !m_prev_wr;
    m_chg = 0;
    if (wr_start) m_step = 0;
    else if (rd_end) begin
      if (m_step < 6 && int'(m_addr) == pre_seq[m_step]) m_step++;
      else begin
        if (m_step == 6 && (m_addr == 16'h041A || m_addr == 16'h040A)) begin
          nf = (m_addr == 16'h040A);
          m_chg = (nf != m_flag);
          m_flag = nf;
        end
        m_step = (m_addr == 16'h1823) ? 1 : 0;
      end
    end
    m_prev_rd = rd_act;
    m_prev_wr = wr_act;
    if (rd_act) m_addr = addr;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk(protect, m_flag, cur, "protect_o");
    chk(prot_chg, m_chg, cur, "prot_chg_o");
    chk(pgm_grant, pgm_req & ~m_flag, cur, "pgm_grant_o");
    chk(ers_grant, ers_req & ~m_flag, cur, "ers_grant_o");
  endtask

  // end_by_ce: release ce_n instead of oe_n; new_addr driven at the ending sample
  task automatic rd(input logic [15:0] a, input bit end_by_ce = 0, input int hold = 1,
                    input logic [15:0] end_addr = 16'h0000);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    for (int i = 0; i < hold; i++) tick();
    addr = end_addr;
    if (end_by_ce) ce_n = 1; else oe_n = 1;
    tick();
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wr(input logic [15:0] a);
    ce_n = 0; oe_n = 1; we_n = 0; addr = a;
    tick();
    we_n = 1;
    tick();
    ce_n = 1;
    tick();
  endtask

  task automatic seq6(input bit by_ce = 0);
    for (int i = 0; i < 6; i++) rd(16'(pre_seq[i]), by_ce);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R1 reset state
    cur = "R1";
    repeat (2) @(negedge clk);
    chk(protect, 1'b1, "R1", "protect_o in reset");
    chk(prot_chg, 1'b0, "R1", "prot_chg_o in reset");
    rst_n = 1;
    tick(); tick();

    // R7 grants blocked while protected
    cur = "R7"; pgm_req = 1; ers_req = 1; tick();
    chk(pgm_grant, 1'b0, "R7", "pgm grant while protected");
    pgm_req = 0; ers_req = 0;

    // R3 clear pattern, reads ended by oe_n
    cur = "R3";
    seq6(); rd(16'h041A);
    chk(protect, 1'b0, "R3", "flag cleared after 7th read");
    chk(prot_chg, 1'b1, "R8", "pulse on clear");
    tick();
    chk(prot_chg, 1'b0, "R8", "pulse lasts one cycle");

    // R7 grants pass while open
    cur = "R7"; pgm_req = 1; tick();
    chk(pgm_grant, 1'b1, "R7", "pgm grant while open");
    ers_req = 1; pgm_req = 0; tick();
    chk(ers_grant, 1'b1, "R7", "ers grant while open");
    ers_req = 0;

    // R6 write carrying FFFFh leaves flag alone
    cur = "R6"; wr(16'hFFFF);
    chk(protect, 1'b0, "R6", "flag after write");

    // R4 set pattern, reads ended by ce_n, long holds (R2)
    cur = "R4";
    for (int i = 0; i < 6; i++) rd(16'(pre_seq[i]), 1, 3);
    rd(16'h040A, 1);
    chk(protect, 1'b1, "R4", "flag set after 7th read");

    // R8 set again while set: no pulse
    cur = "R8";
    seq6(); rd(16'h040A);
    chk(prot_chg, 1'b0, "R8", "no pulse without change");
    chk(protect, 1'b1, "R8", "flag stays set");

    // R2 address change at ending sample is ignored
    cur = "R2";
    for (int i = 0; i < 6; i++) rd(16'(pre_seq[i]), 0, 1, 16'hBEEF);
    rd(16'h041A, 0, 1, 16'h040A);
    chk(protect, 1'b0, "R2", "address latched before read end");

    // R5 mismatch restarts; 1823 counts as step one
    cur = "R5";
    rd(16'h1823); rd(16'h1820); rd(16'h1234);
    rd(16'h0418); rd(16'h041B); rd(16'h0419); rd(16'h040A);
    chk(protect, 1'b0, "R5", "broken pattern ignored");
    rd(16'h1823); rd(16'h1820);
    seq6(); rd(16'h040A);
    chk(protect, 1'b1, "R5", "restart on 1823 completes");
    seq6(); rd(16'h1823);
    for (int i = 1; i < 6; i++) rd(16'(pre_seq[i]));
    rd(16'h041A);
    chk(protect, 1'b0, "R5", "1823 at last step is step one");

    // R6 write in the middle cancels
    cur = "R6";
    rd(16'h1823); rd(16'h1820); rd(16'h1822);
    wr(16'h0010);
    rd(16'h0418); rd(16'h041B); rd(16'h0419); rd(16'h040A);
    chk(protect, 1'b0, "R6", "write cancels pattern");
    seq6();
    // read end and write start in the same sample: write wins
    ce_n = 0; oe_n = 0; we_n = 1; addr = 16'h040A; tick();
    oe_n = 1; we_n = 0; tick();
    we_n = 1; tick(); ce_n = 1; tick();
    chk(protect, 1'b0, "R6", "write beats simultaneous read end");

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule